// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides who owns a shared bus: the CPU or one of two DMA channels. Each channel has a request line, an enable and a one-bit pending flag. Request lines are looked at once per bus-clock period, at the falling edge of the bus clock. An enabled request seen at that sample sets the channel's flag. The bus is taken from the CPU only when the CPU signals that it has finished a bus access. The arbiter then hands the bus to the highest-priority pending channel for a single transfer. When that transfer ends, the bus goes back to the CPU.

Because the bus always returns to the CPU after one transfer, the CPU gets at least one bus access between any two DMA transfers. This holds even when both channels are waiting. A flag holds only one request, so requests that pile up before service collapse into one transfer. The flag is cleared when its channel wins the bus. Any request sampled during the transfer therefore queues one more transfer.

Top module: `dmarb_top`

## Requirements
- R1: After synchronous reset, `gnt_cpu` is 1, `gnt_dma` is 0 and no channel is pending. A `cpu_done` pulse with no request sampled leaves the CPU owning the bus.
- R2: Request levels are sampled only at a falling edge of `bus_clk`, and at most once per bus-clock period. A request raised and dropped while `bus_clk` stays high is never captured.
- R3: A request sampled while its channel's enable is 0 does not set that channel's pending flag.
- R4: Driving a channel's enable to 0 clears that channel's pending flag. Turning the enable back on does not bring the request back.
- R5: While the CPU owns the bus, a `cpu_done` pulse with at least one enabled pending channel grants the bus on the next clock edge. Channel 0 wins over channel 1.
- R6: A DMA grant stays unchanged until `xfer_done`. The next clock edge after `xfer_done` returns the bus to the CPU.
- R7: A channel can be granted only from CPU ownership and only on `cpu_done`. Between two DMA transfers there is always at least one completed CPU access, even when both channels were requested in the same period.
- R8: Several requests sampled before a channel is served produce exactly one transfer.
- R9: A channel's pending flag is cleared on the edge that grants it the bus. A request sampled during that transfer sets the flag again and gives exactly one further transfer.
- R10: Exactly one of `gnt_cpu`, `gnt_dma[0]` and `gnt_dma[1]` is 1 at all times. `gnt_dma[i]` means channel i owns the bus.
- R11: `cpu_done` has no effect while a channel owns the bus. `xfer_done` has no effect while the CPU owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Bus clock; its falling edge is the sample point |
| dma_req | input | 2 | Request level per channel (bit i = channel i) |
| ch_en | input | 2 | Enable per channel |
| cpu_done | input | 1 | One-cycle strobe: the CPU finished a bus access |
| xfer_done | input | 1 | One-cycle strobe: the granted DMA transfer finished |
| gnt_cpu | output | 1 | CPU owns the bus |
| gnt_dma | output | 2 | Channel i owns the bus when bit i is 1 |

## Verification
The bench sets both requests in the same period and expects channel 0, then a CPU access, then channel 1. A design that skipped the CPU turn would chain the two transfers. A design with the priority reversed would serve channel 1 first. Repeated requests before service must give one transfer, not one per request. A request seen during a transfer must give exactly one more, which a design that cleared the flag at transfer end would lose. Disabled channels, requests that vanish before the sample edge, and strobes that arrive in the wrong ownership state are all checked at the grant outputs, where a design that counted them would hand out an extra grant.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef logic [NUM_CH-1:0] ch_vec_t;

    // Bus owner: dma=0 means CPU, otherwise channel index in ch
    typedef struct packed {
        logic            dma;
        logic [CH_W-1:0] ch;
    } owner_t;

    localparam owner_t OWNER_CPU = '{dma: 1'b0, ch: '0};

    // Lowest index wins
    function automatic logic [CH_W-1:0] pick_channel(ch_vec_t v);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (v[i]) r = CH_W'(i);
        end
        return r;
    endfunction

    function automatic ch_vec_t channel_onehot(logic [CH_W-1:0] idx);
        ch_vec_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

    function automatic ch_vec_t owner_grants(owner_t o);
        return o.dma ? channel_onehot(o.ch) : '0;
    endfunction

endpackage

// File: rtl/dmarb_sync.sv
module dmarb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[k] <= '0;
            else     stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dmarb_sampler.sv
module dmarb_sampler
    import dmarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_clk,
    input  ch_vec_t req_raw,
    output logic    sample_stb,
    output ch_vec_t req_seen
);
    localparam int SW = NUM_CH + 1;

    logic [SW-1:0] sync_q;
    logic          bclk_s;
    logic          bclk_prev;
    ch_vec_t       req_s;

    dmarb_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_clk, req_raw}),
        .q   (sync_q)
    );

    assign bclk_s = sync_q[SW-1];
    assign req_s  = sync_q[NUM_CH-1:0];

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= bclk_s;
    end

    // One strobe per bus-clock falling edge
    assign sample_stb = bclk_prev & ~bclk_s;
    assign req_seen   = sample_stb ? req_s : '0;

    // R2: a sample strobe is never followed by another on the next cycle
    assert_one_sample_R2: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);
endmodule

// File: rtl/dmarb_pending.sv
module dmarb_pending
    import dmarb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t en,
    input  ch_vec_t set_req,
    input  ch_vec_t clr_grant,
    output ch_vec_t pend
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)               pend[i] <= 1'b0;
            else if (!en[i])       pend[i] <= 1'b0;
            else if (set_req[i])   pend[i] <= 1'b1;
            else if (clr_grant[i]) pend[i] <= 1'b0;
        end

        // R3, R4: a disabled channel holds no pending request
        assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (rst)
            !en[i] |=> !pend[i]);

        // R9: granting clears the flag unless a fresh sample lands on the same edge
        assert_clear_on_grant_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_grant[i] && !set_req[i]) |=> !pend[i]);

        // R8: a request on an already pending channel leaves one pending flag
        assert_merge_R8: assert property (@(posedge clk) disable iff (rst)
            (en[i] && set_req[i]) |=> pend[i]);
    end
endmodule

// File: rtl/dmarb_owner.sv
module dmarb_owner
    import dmarb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t pend_eff,
    input  logic    cpu_done,
    input  logic    xfer_done,
    output owner_t  owner,
    output ch_vec_t grant_stb
);
    owner_t owner_nxt;
    logic   take_bus;

    assign take_bus = !owner.dma && cpu_done && (|pend_eff);

    always_comb begin
        owner_nxt = owner;
        grant_stb = '0;
        if (owner.dma) begin
            if (xfer_done) owner_nxt = OWNER_CPU;
        end else if (take_bus) begin
            owner_nxt.dma = 1'b1;
            owner_nxt.ch  = pick_channel(pend_eff);
            grant_stb     = channel_onehot(owner_nxt.ch);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) owner <= OWNER_CPU;
        else     owner <= owner_nxt;
    end

    // R5: channel 0 wins whenever it is pending at the hand-over
    assert_prio_R5: assert property (@(posedge clk) disable iff (rst)
        (!owner.dma && cpu_done && pend_eff[0]) |=> (owner.dma && owner.ch == '0));

    // R6: DMA ownership is held until the transfer ends
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (owner.dma && !xfer_done) |=> $stable(owner));

    // R6: transfer end returns the bus to the CPU
    assert_return_R6: assert property (@(posedge clk) disable iff (rst)
        (owner.dma && xfer_done) |=> !owner.dma);

    // R7, R11: without cpu_done the CPU keeps the bus
    assert_cpu_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (!owner.dma && !cpu_done) |=> !owner.dma);
endmodule

// File: rtl/dmarb_top.sv
module dmarb_top
    import dmarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_clk,
    input  logic [NUM_CH-1:0]   dma_req,
    input  logic [NUM_CH-1:0]   ch_en,
    input  logic                cpu_done,
    input  logic                xfer_done,
    output logic                gnt_cpu,
    output logic [NUM_CH-1:0]   gnt_dma
);
    ch_vec_t req_seen;
    ch_vec_t pend;
    ch_vec_t pend_eff;
    ch_vec_t grant_stb;
    owner_t  owner;
    logic    sample_stb;

    dmarb_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .bus_clk    (bus_clk),
        .req_raw    (dma_req),
        .sample_stb (sample_stb),
        .req_seen   (req_seen)
    );

    dmarb_pending u_pending (
        .clk       (clk),
        .rst       (rst),
        .en        (ch_en),
        .set_req   (req_seen),
        .clr_grant (grant_stb),
        .pend      (pend)
    );

    assign pend_eff = pend & ch_en;

    dmarb_owner u_owner (
        .clk       (clk),
        .rst       (rst),
        .pend_eff  (pend_eff),
        .cpu_done  (cpu_done),
        .xfer_done (xfer_done),
        .owner     (owner),
        .grant_stb (grant_stb)
    );

    assign gnt_cpu = !owner.dma;
    assign gnt_dma = owner_grants(owner);

    // R10: exactly one owner
    assert_one_owner_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({gnt_cpu, gnt_dma}) == 1);

    // R2: requests only register on a sample strobe
    assert_sample_only_R2: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |-> (req_seen == '0));
endmodule

// File: tb/dmarb_top_bench.sv
module dmarb_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_clk = 1'b0;
    logic [1:0] dma_req = '0;
    logic [1:0] ch_en = '0;
    logic       cpu_done = 1'b0;
    logic       xfer_done = 1'b0;
    logic       gnt_cpu;
    logic [1:0] gnt_dma;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Model state: 0 = CPU, 1 = channel 0, 2 = channel 1
    int         m_own = 0;
    logic [1:0] m_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmarb_top u_dmarb_top (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .dma_req(dma_req), .ch_en(ch_en),
        .cpu_done(cpu_done), .xfer_done(xfer_done), .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma)
    );

    function automatic logic [2:0] exp_grants(int own);
        case (own)
            1:       return 3'b001;
            2:       return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic int winner(logic [1:0] p);
        return p[0] ? 1 : 2;
    endfunction

    task automatic check_grants(string req);
        logic [2:0] act;
        logic [2:0] exp;
        act = {gnt_cpu, gnt_dma};
        exp = exp_grants(m_own);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s grants actual=%b expected=%b", req, act, exp);
        end
        checks++;
        if ($countones(act) != 1) begin
            fails++;
            $display("FAIL R10 onehot actual=%b expected=one bit set", act);
        end
    endtask

    // One bus-clock period with the given request level held around the falling edge
    task automatic bus_period(logic [1:0] r);
        @(negedge clk); bus_clk = 1'b1; dma_req = r;
        repeat (4) @(negedge clk);
        bus_clk = 1'b0;
        repeat (6) @(negedge clk);
        dma_req = '0;
        m_pend = m_pend | (r & ch_en);
    endtask

    task automatic set_enable(logic [1:0] e);
        @(negedge clk); ch_en = e;
        repeat (2) @(negedge clk);
        m_pend = m_pend & e;
    endtask

    task automatic pulse_cpu_done(string req);
        @(negedge clk); cpu_done = 1'b1;
        @(negedge clk); cpu_done = 1'b0;
        if (m_own == 0 && (m_pend & ch_en) != 2'b00) begin
            m_own = winner(m_pend & ch_en);
            m_pend[m_own-1] = 1'b0;
        end
        check_grants(req);
    endtask

    task automatic pulse_xfer_done(string req);
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        if (m_own != 0) m_own = 0;
        check_grants(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_grants("R1 reset");
        ch_en = 2'b11;
        repeat (2) @(negedge clk);
        pulse_cpu_done("R1 idle cpu_done");

        // R5, R7: both in the same period, channel 0 first, CPU in between
        bus_period(2'b11);
        pulse_cpu_done("R5 ch0 first");
        pulse_cpu_done("R11 cpu_done during DMA");
        repeat (3) @(negedge clk);
        check_grants("R6 held until xfer_done");
        pulse_xfer_done("R6 back to cpu");
        pulse_cpu_done("R7 ch1 after cpu access");
        pulse_xfer_done("R6 ch1 done");
        pulse_xfer_done("R11 xfer_done while CPU owns");

        // R8: repeated requests merge
        bus_period(2'b10); bus_period(2'b10); bus_period(2'b10);
        pulse_cpu_done("R8 single ch1 transfer");
        pulse_xfer_done("R8 done");
        pulse_cpu_done("R8 no second transfer");

        // R9: request during service gives one more
        bus_period(2'b01);
        pulse_cpu_done("R9 ch0 granted");
        bus_period(2'b01);
        pulse_xfer_done("R9 done");
        pulse_cpu_done("R9 re-request served");
        pulse_xfer_done("R9 done again");
        pulse_cpu_done("R9 nothing left");

        // R3: disabled channel ignored
        set_enable(2'b10);
        bus_period(2'b01);
        pulse_cpu_done("R3 disabled ignored");
        set_enable(2'b11);
        pulse_cpu_done("R3 still ignored");

        // R4: disable clears pending
        bus_period(2'b10);
        set_enable(2'b01);
        set_enable(2'b11);
        pulse_cpu_done("R4 cleared by disable");

        // R2: pulse entirely inside the high phase is missed
        @(negedge clk); bus_clk = 1'b1;
        repeat (2) @(negedge clk); dma_req = 2'b11;
        repeat (2) @(negedge clk); dma_req = 2'b00;
        repeat (2) @(negedge clk); bus_clk = 1'b0;
        repeat (6) @(negedge clk);
        pulse_cpu_done("R2 pulse between samples");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int act;
            act = $urandom_range(0, 9);
            if (act < 4)       bus_period(2'($urandom_range(0, 3)));
            else if (act < 7)  pulse_cpu_done("R5 random");
            else if (act < 9)  pulse_xfer_done("R6 random");
            else               set_enable(($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b11);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule